// File: doc/BRIEF.md
# Banked Window Address Translator

This block sits between a 16-bit CPU address bus and a wider 32-bit virtual address space. A programmable window inside the CPU map is redirected. A CPU address that falls inside the window has the window start subtracted from it. The page number, shifted left by a programmable amount, is added, and a programmable virtual base is added on top. Every address outside the window leaves the block unchanged, zero-extended to 32 bits. The page number is held in a register that software both writes and reads back.

The block also holds an 8-bit initialisation register, which places two fixed-size blocks in the CPU map. Its low nibble selects address bits [15:12] of the on-chip I/O register block. Its high nibble selects address bits [15:12] of the internal RAM block. Two flags report whether the current CPU address falls in either block. The I/O block size depends on the CPU variant, which an input selects.

All registers update on the rising clock edge. The translated address and both hit flags are combinational from the CPU address and the registered values.

Top module: `bank_window_xlat`

## Requirements
- R1: An address is passed through as `{16'h0000, cpu_addr}` unless it satisfies win_start <= cpu_addr < win_end. The window end is exclusive, and a window whose end is not above its start translates nothing.
- R2: Inside the window, xlat_addr = (cpu_addr - win_start) + (page << shift) + vbase, computed modulo 2^32. in_window is 1 exactly in this case.
- R3: A page_we pulse stores page_wdata at the next rising edge. page_rd always shows the stored page, and the page resets to 0.
- R4: A shift write whose value exceeds 16 stores 16. Smaller values are stored as written.
- R5: The initialisation register resets to 0x01 and is loaded from init_wdata only when init_we is 1. Bits [3:0] give I/O base address bits [15:12], and bits [7:4] give RAM base address bits [15:12].
- R6: io_hit is 1 exactly when io_base <= cpu_addr < io_base + size. The size is 64 bytes when wide_io is 0 and 1024 bytes when wide_io is 1.
- R7: ram_hit is 1 exactly when ram_base <= cpu_addr < ram_base + 256.
- R8: A configuration write happens only when cfg_we is 1. cfg_sel selects the target: 0 is the window start (cfg_wdata[15:0]), 1 is the window end (cfg_wdata[15:0]), 2 is the shift, and 3 is the virtual base (cfg_wdata[31:0]).
- R9: After reset, the window start is 0x8000, the window end is 0xC000, the shift is 14 and the virtual base is 0x0010_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address to translate and decode |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 8 | Page register write data |
| page_rd | output | 8 | Page register read value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select (0 start, 1 end, 2 shift, 3 vbase) |
| cfg_wdata | input | 32 | Configuration write data |
| init_we | input | 1 | Initialisation register write strobe |
| init_wdata | input | 8 | Initialisation register write data |
| wide_io | input | 1 | Variant select: 0 selects a 64-byte I/O block, 1 selects a 1024-byte I/O block |
| xlat_addr | output | 32 | Translated address |
| in_window | output | 1 | Address lies inside the banked window |
| io_hit | output | 1 | Address lies inside the I/O register block |
| ram_hit | output | 1 | Address lies inside the internal RAM block |

## Verification
The bench probes both window edges: the last address inside, the first address at the end, the start itself, and a window whose end equals its start. A comparison that is off by one, or inclusive at the end, would translate an address that should pass through. It writes a shift of 20 and checks that the page lands at bit 16. A missing clamp would move the page far above that. It also sets up a sum that carries past bit 31 and expects a wrapped result. The I/O and RAM edges are tested for both I/O sizes and after relocation. A wrong nibble or a swapped size would move a hit flag one block or one boundary away. Writes with their strobe low must leave the translation and the hit flags as they were.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int CPU_AW = 16;
    localparam int VA_W   = 32;
    localparam int SH_W   = 5;

    typedef enum logic [1:0] {
        FLD_WIN_START = 2'd0,
        FLD_WIN_END   = 2'd1,
        FLD_SHIFT     = 2'd2,
        FLD_VBASE     = 2'd3
    } cfg_field_e;

    typedef struct packed {
        logic [CPU_AW-1:0] win_start;
        logic [CPU_AW-1:0] win_end;
        logic [SH_W-1:0]   shift;
        logic [VA_W-1:0]   vbase;
    } win_cfg_t;

endpackage

// File: rtl/bwt_cfg_regs.sv
module bwt_cfg_regs
    import bwt_pkg::*;
#(
    parameter logic [CPU_AW-1:0] RST_START = 16'h8000,
    parameter logic [CPU_AW-1:0] RST_END   = 16'hC000,
    parameter int                RST_SHIFT = 14,
    parameter logic [VA_W-1:0]   RST_VBASE = 32'h0010_0000,
    parameter int                SHIFT_MAX = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [VA_W-1:0] cfg_wdata,
    output win_cfg_t        cfg_q
);
    localparam logic [SH_W-1:0] SH_LIMIT = SH_W'(SHIFT_MAX);
    localparam logic [SH_W-1:0] SH_RESET = SH_W'(RST_SHIFT);

    cfg_field_e      field;
    logic [SH_W-1:0] shift_clip;

    assign field = cfg_field_e'(cfg_sel);

    always_comb begin
        if (cfg_wdata > VA_W'(SHIFT_MAX)) begin
            shift_clip = SH_LIMIT;
        end else begin
            shift_clip = cfg_wdata[SH_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.win_start <= RST_START;
            cfg_q.win_end   <= RST_END;
            cfg_q.shift     <= SH_RESET;
            cfg_q.vbase     <= RST_VBASE;
        end else if (cfg_we) begin
            unique case (field)
                FLD_WIN_START: cfg_q.win_start <= cfg_wdata[CPU_AW-1:0];
                FLD_WIN_END:   cfg_q.win_end   <= cfg_wdata[CPU_AW-1:0];
                FLD_SHIFT:     cfg_q.shift     <= shift_clip;
                FLD_VBASE:     cfg_q.vbase     <= cfg_wdata;
            endcase
        end
    end

endmodule

// File: rtl/bwt_cpu_regs.sv
module bwt_cpu_regs #(
    parameter int         PAGE_W   = 8,
    parameter logic [7:0] INIT_RST = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              init_we,
    input  logic [7:0]        init_wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [7:0]        init_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (page_we) begin
            page_q <= page_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= INIT_RST;
        end else if (init_we) begin
            init_q <= init_wdata;
        end
    end

endmodule

// File: rtl/bwt_window_xlate.sv
module bwt_window_xlate
    import bwt_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [PAGE_W-1:0] page_q,
    input  win_cfg_t          cfg_q,
    output logic [VA_W-1:0]   xlat_addr,
    output logic              in_window
);
    localparam int PAD_OFS  = VA_W - CPU_AW;
    localparam int PAD_PAGE = VA_W - PAGE_W;

    logic [CPU_AW-1:0] offset;
    logic [VA_W-1:0]   page_term;

    always_comb begin
        in_window = (cpu_addr >= cfg_q.win_start) && (cpu_addr < cfg_q.win_end);
        offset    = cpu_addr - cfg_q.win_start;
        page_term = {{PAD_PAGE{1'b0}}, page_q} << cfg_q.shift;
        if (in_window) begin
            xlat_addr = {{PAD_OFS{1'b0}}, offset} + page_term + cfg_q.vbase;
        end else begin
            xlat_addr = {{PAD_OFS{1'b0}}, cpu_addr};
        end
    end

endmodule

// File: rtl/bwt_block_decode.sv
module bwt_block_decode
    import bwt_pkg::*;
#(
    parameter int IO_SMALL  = 64,
    parameter int IO_LARGE  = 1024,
    parameter int RAM_BYTES = 256
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        init_q,
    input  logic              wide_io,
    output logic              io_hit,
    output logic              ram_hit
);
    localparam int EW = CPU_AW + 1;
    localparam logic [EW-1:0] IO_SZ_S = EW'(IO_SMALL);
    localparam logic [EW-1:0] IO_SZ_L = EW'(IO_LARGE);
    localparam logic [EW-1:0] RAM_SZ  = EW'(RAM_BYTES);

    logic [EW-1:0] addr_x;
    logic [EW-1:0] io_lo;
    logic [EW-1:0] ram_lo;
    logic [EW-1:0] io_sz;

    always_comb begin
        addr_x  = {1'b0, cpu_addr};
        io_lo   = {1'b0, init_q[3:0], 12'h000};
        ram_lo  = {1'b0, init_q[7:4], 12'h000};
        io_sz   = wide_io ? IO_SZ_L : IO_SZ_S;
        io_hit  = (addr_x >= io_lo)  && (addr_x < io_lo + io_sz);
        ram_hit = (addr_x >= ram_lo) && (addr_x < ram_lo + RAM_SZ);
    end

endmodule

// File: rtl/bank_window_xlat.sv
module bank_window_xlat
    import bwt_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int SHIFT_MAX = 16,
    parameter int IO_SMALL  = 64,
    parameter int IO_LARGE  = 1024,
    parameter int RAM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    output logic [PAGE_W-1:0] page_rd,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              init_we,
    input  logic [7:0]        init_wdata,
    input  logic              wide_io,
    output logic [31:0]       xlat_addr,
    output logic              in_window,
    output logic              io_hit,
    output logic              ram_hit
);

    win_cfg_t          cfg_q;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        init_q;

    bwt_cfg_regs #(
        .SHIFT_MAX (SHIFT_MAX)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q)
    );

    bwt_cpu_regs #(
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_we    (page_we),
        .page_wdata (page_wdata),
        .init_we    (init_we),
        .init_wdata (init_wdata),
        .page_q     (page_q),
        .init_q     (init_q)
    );

    bwt_window_xlate #(
        .PAGE_W (PAGE_W)
    ) u_xlate (
        .cpu_addr  (cpu_addr),
        .page_q    (page_q),
        .cfg_q     (cfg_q),
        .xlat_addr (xlat_addr),
        .in_window (in_window)
    );

    bwt_block_decode #(
        .IO_SMALL  (IO_SMALL),
        .IO_LARGE  (IO_LARGE),
        .RAM_BYTES (RAM_BYTES)
    ) u_decode (
        .cpu_addr (cpu_addr),
        .init_q   (init_q),
        .wide_io  (wide_io),
        .io_hit   (io_hit),
        .ram_hit  (ram_hit)
    );

    assign page_rd = page_q;

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker
    import bwt_pkg::*;
#(
    parameter int PAGE_W    = 8,
    parameter int SHIFT_MAX = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              page_we,
    input logic [PAGE_W-1:0] page_wdata,
    input logic [PAGE_W-1:0] page_rd,
    input logic              cfg_we,
    input logic              init_we,
    input logic [31:0]       xlat_addr,
    input logic              io_hit,
    input logic              ram_hit,
    input win_cfg_t          cfg_q,
    input logic [7:0]        init_q
);

    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < cfg_q.win_start || cpu_addr >= cfg_q.win_end)
            |-> (xlat_addr == {16'h0000, cpu_addr}));

    p_page_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |=> (page_rd == $past(page_wdata)));

    p_shift_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.shift <= SH_W'(SHIFT_MAX));

    p_init_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !init_we |=> $stable(init_q));

    p_io_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == {init_q[3:0], 12'h000}) |-> io_hit);

    p_ram_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == {init_q[7:4], 12'h000}) |-> ram_hit);

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

bind bank_window_xlat bwt_checker #(
    .PAGE_W    (PAGE_W),
    .SHIFT_MAX (SHIFT_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .page_we    (page_we),
    .page_wdata (page_wdata),
    .page_rd    (page_rd),
    .cfg_we     (cfg_we),
    .init_we    (init_we),
    .xlat_addr  (xlat_addr),
    .io_hit     (io_hit),
    .ram_hit    (ram_hit),
    .cfg_q      (cfg_q),
    .init_q     (init_q)
);

// File: tb/bank_window_xlat_tb.sv
`timescale 1ns/1ps
module bank_window_xlat_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic [7:0]  page_rd;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        init_we = 1'b0;
    logic [7:0]  init_wdata = '0;
    logic        wide_io = 1'b0;
    logic [31:0] xlat_addr;
    logic        in_window;
    logic        io_hit;
    logic        ram_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bank_window_xlat u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .page_we    (page_we),
        .page_wdata (page_wdata),
        .page_rd    (page_rd),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .init_we    (init_we),
        .init_wdata (init_wdata),
        .wide_io    (wide_io),
        .xlat_addr  (xlat_addr),
        .in_window  (in_window),
        .io_hit     (io_hit),
        .ram_hit    (ram_hit)
    );

    // Vector entries: {cpu_addr, page, expected xlat_addr}, with the reset window (R9).
    localparam logic [55:0] VEC [8] = '{
        {16'h8000, 8'h00, 32'h0010_0000},
        {16'h8123, 8'h01, 32'h0010_4123},
        {16'hBFFF, 8'h03, 32'h0010_FFFF},
        {16'hC000, 8'h05, 32'h0000_C000},
        {16'h7FFF, 8'h05, 32'h0000_7FFF},
        {16'hA000, 8'hFF, 32'h004F_E000},
        {16'h0000, 8'h02, 32'h0000_0000},
        {16'hFFFF, 8'h02, 32'h0000_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_page(input logic [7:0] v);
        @(negedge clk);
        page_we = 1'b1; page_wdata = v;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [31:0] v, input logic en);
        @(negedge clk);
        cfg_we = en; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_init(input logic [7:0] v, input logic en);
        @(negedge clk);
        init_we = en; init_wdata = v;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R3, R5, R6, R7
        check("R3 reset page", 32'(page_rd), 32'h0);
        probe(16'h1000); check("R6 io at 0x1000 after reset", 32'(io_hit), 32'h1);
        probe(16'h103F); check("R6 io last small byte", 32'(io_hit), 32'h1);
        probe(16'h1040); check("R6 io past small block", 32'(io_hit), 32'h0);
        probe(16'h0000); check("R7 ram at 0x0000 after reset", 32'(ram_hit), 32'h1);
        probe(16'h00FF); check("R7 ram last byte", 32'(ram_hit), 32'h1);
        probe(16'h0100); check("R7 ram past block", 32'(ram_hit), 32'h0);
        wide_io = 1'b1;
        probe(16'h13FF); check("R6 io last large byte", 32'(io_hit), 32'h1);
        probe(16'h1400); check("R6 io past large block", 32'(io_hit), 32'h0);
        wide_io = 1'b0;

        // Vector walk: R1, R2, R9
        for (int i = 0; i < 8; i++) begin
            wr_page(VEC[i][39:32]);
            probe(VEC[i][55:40]);
            check($sformatf("R2 R1 R9 vector %0d", i), xlat_addr, VEC[i][31:0]);
        end
        probe(16'hBFFF); check("R2 in_window inside", 32'(in_window), 32'h1);
        probe(16'hC000); check("R1 in_window at end", 32'(in_window), 32'h0);

        // Relocation: R5
        wr_init(8'h3A, 1'b1);
        probe(16'hA000); check("R5 io relocated", 32'(io_hit), 32'h1);
        probe(16'h1000); check("R5 io old base", 32'(io_hit), 32'h0);
        probe(16'h30FF); check("R5 ram relocated", 32'(ram_hit), 32'h1);
        wr_init(8'h01, 1'b0);
        probe(16'hA000); check("R5 init write ignored", 32'(io_hit), 32'h1);

        // Shift clamp: R4
        wr_cfg(2'd2, 32'd20, 1'b1);
        wr_page(8'h01);
        probe(16'h8000); check("R4 shift clipped to 16", xlat_addr, 32'h0011_0000);

        // Wrap: R2, R8
        wr_cfg(2'd3, 32'hFFFF_FF00, 1'b1);
        wr_cfg(2'd2, 32'd0, 1'b1);
        wr_page(8'h10);
        check("R3 page readback", 32'(page_rd), 32'h10);
        probe(16'h80F0); check("R2 sum wraps", xlat_addr, 32'h0000_0000);

        // Strobe-low write ignored: R8
        wr_cfg(2'd0, 32'h0000_0000, 1'b0);
        probe(16'h7FFF); check("R8 cfg write ignored", xlat_addr, 32'h0000_7FFF);

        // New window: R8, R1
        wr_cfg(2'd3, 32'h0002_0000, 1'b1);
        wr_cfg(2'd0, 32'h0000_4000, 1'b1);
        wr_cfg(2'd1, 32'h0000_5000, 1'b1);
        probe(16'h4FFF); check("R8 new window last", xlat_addr, 32'h0002_100F);
        probe(16'h4000); check("R8 new window start", xlat_addr, 32'h0002_0010);
        probe(16'h5000); check("R1 new window end excluded", xlat_addr, 32'h0000_5000);

        // Empty window: R1
        wr_cfg(2'd1, 32'h0000_4000, 1'b1);
        probe(16'h4000); check("R1 empty window", xlat_addr, 32'h0000_4000);
        check("R1 empty window flag", 32'(in_window), 32'h0);

        finish_run();
    end

endmodule